// File: doc/BRIEF.md
# Handshaked Byte-Link Host Controller

This block runs the host end of a half-duplex byte link to a peripheral microcontroller. Bits are shifted by a separate shift register. The controller frames each transfer with two active-low control lines: a frame-active level (`tip_no`) and a per-byte acknowledge line (`ack_no`) that toggles once for each byte. It samples an active-low request line (`req_ni`) from the peripheral. It reacts to the shift register's byte-complete pulse, loads outgoing bytes into the shift register, takes incoming bytes from it, and sets its shift direction.

On the host side, an outgoing packet (a type byte followed by payload) is streamed into a small store and stays pending until it has gone out in full. Incoming frames are streamed out byte by byte, with marks for the first and last byte, the frame length and an overflow flag. The peripheral's request line has priority. When the request is asserted during a host send, the controller abandons the send, takes the byte as the start of an incoming frame, and later resends the packet from its first byte. Guard delays of 150 µs and 1500 µs come from a clock-rate parameter. A fixed reset handshake runs after power-up.

Top module: `link_host_ctrl`

## Requirements
- R1: After reset the controller runs its handshake in this order, with 150 µs (150·CLK_HZ/10⁶ cycles) between steps: both lines high, `tip_no` low, `ack_no` toggled low, `tip_no` high, `ack_no` high.
- R2: In the idle state `tip_no` and `ack_no` are high and `sr_dir_o` is 0 (shift in). These values also hold from reset onward.
- R3: A send starts only in idle while `req_ni` is 1. In the same cycle `sr_dir_o` becomes 1, byte 0 is loaded (`sr_load_o` pulse with `sr_wdata_o`), `ack_no` is high and `tip_no` goes low.
- R4: During a send, each `sr_done_i` pulse with `req_ni`=1 either loads the next byte and toggles `ack_no`, or, after the last byte, returns to idle (tip/ack high, direction in) and clears the pending packet so that `tx_ready_o` returns to 1.
- R5: An `sr_done_i` pulse during a send while `req_ni` is 0 aborts the send. The byte on `sr_rdata_i` is delivered as the type byte of a new incoming frame, and the packet is later resent starting at byte 0.
- R6: An `sr_done_i` pulse in idle while `req_ni` is 0 starts a receive. The byte is delivered with `rx_first_o`=1, `tip_no` goes low and `sr_dir_o` is 0.
- R7: During a receive, each byte is delivered on `rx_valid_o`/`rx_data_o`. If `req_ni` is 0 at that pulse, `ack_no` toggles. If `req_ni` is 1, the byte is the last one: `rx_last_o`=1, `rx_len_o` equals the byte count including the type byte, and tip/ack return high.
- R8: A frame is capped at RX_CAP (default 256) bytes. A byte that reaches the cap while `req_ni` is still 0 ends the frame with `rx_ovf_o`=1 and `rx_len_o`=RX_CAP.
- R9: An `sr_done_i` pulse in idle while `req_ni` is 1 delivers no byte. If a packet is pending at that moment, its send begins only after a 150 µs wait.
- R10: When a received frame ends with a packet pending, no send starts for 1500 µs. After that, the send proceeds only if `req_ni` is 1; otherwise the controller stays idle to receive.
- R11: An `sr_done_i` pulse that arrives during a guard delay is held and handled in idle once the delay ends.
- R12: `tx_ready_o` is 0 from the cycle after a byte marked `tx_last_i` is accepted until that packet completes. Bytes offered while it is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Outgoing packet byte valid |
| tx_data_i | input | 8 | Outgoing packet byte (first byte is the type) |
| tx_last_i | input | 1 | Marks the final byte of the outgoing packet |
| tx_ready_o | output | 1 | Store can take bytes (no packet pending) |
| rx_valid_o | output | 1 | Incoming byte valid (one cycle) |
| rx_data_o | output | 8 | Incoming byte |
| rx_first_o | output | 1 | Byte is the frame's type byte |
| rx_last_o | output | 1 | Byte ends the frame |
| rx_len_o | output | 9 | Frame byte count, valid with rx_last_o |
| rx_ovf_o | output | 1 | Frame ended by the size cap |
| sr_done_i | input | 1 | Shift register byte-complete pulse |
| sr_rdata_i | input | 8 | Byte held by the shift register |
| sr_load_o | output | 1 | Load sr_wdata_o into the shift register |
| sr_wdata_o | output | 8 | Byte to shift out |
| sr_dir_o | output | 1 | Shift direction, 1 = out to peripheral |
| req_ni | input | 1 | Peripheral request, active low |
| tip_no | output | 1 | Frame in progress, active low |
| ack_no | output | 1 | Byte acknowledge, toggled per byte |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a byte-complete pulse and the first cycle in which a freshly stored packet could start its send. The bench raises the pulse on exactly the cycle after the last packet byte is accepted, and it judges the outcome by the first load arriving no sooner than the 150 µs false-start wait. The second pair is a byte-complete pulse during a send and an asserted request. Here the bench expects that byte back on the receive stream as a type byte, and it expects the scoreboard to see the packet's first byte loaded a second time after the 1500 µs wait.

// File: rtl/lk_pkg.sv
package lk_pkg;
  typedef enum logic [3:0] {
    LK_RST0,
    LK_RST1,
    LK_RST2,
    LK_RST3,
    LK_IDLE,
    LK_SEND,
    LK_RECV,
    LK_GAP_SHORT,
    LK_GAP_LONG
  } lk_state_e;
endpackage

// File: rtl/lk_delay_timer.sv
module lk_delay_timer #(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic short_hit_o,
  output logic long_hit_o
);
  localparam int CYC_US = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int SHORT  = 150 * CYC_US;
  localparam int LONG   = 1500 * CYC_US;
  localparam int CW     = $clog2(LONG + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (cnt_q != CW'(LONG)) cnt_q <= cnt_q + CW'(1);
  end

  assign short_hit_o = (cnt_q == CW'(SHORT - 1));
  assign long_hit_o  = (cnt_q == CW'(LONG - 1));
endmodule

// File: rtl/lk_tx_store.sv
module lk_tx_store #(
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [7:0]                 in_data_i,
  input  logic                       in_last_i,
  output logic                       in_ready_o,
  input  logic                       clear_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [7:0]                 rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] len_o,
  output logic                       pending_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] wr_q;
  logic [LW-1:0] len_q;
  logic          pend_q;
  logic          accept;
  logic          closing;

  assign accept  = in_valid_i && !pend_q;
  assign closing = in_last_i || (wr_q == IW'(DEPTH - 1));

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_q] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      len_q  <= '0;
      pend_q <= 1'b0;
    end else if (accept) begin
      if (closing) begin
        pend_q <= 1'b1;
        len_q  <= LW'(wr_q) + LW'(1);
        wr_q   <= '0;
      end else begin
        wr_q <= wr_q + IW'(1);
      end
    end else if (clear_i) begin
      pend_q <= 1'b0;
    end
  end

  assign in_ready_o = !pend_q;
  assign rd_data_o  = mem_q[rd_idx_i];
  assign len_o      = len_q;
  assign pending_o  = pend_q;
endmodule

// File: rtl/lk_link_fsm.sv
module lk_link_fsm
  import lk_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_CAP   = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_ni,
  input  logic                          sr_done_i,
  input  logic [7:0]                    sr_rdata_i,
  input  logic                          pending_i,
  input  logic [$clog2(TX_DEPTH+1)-1:0] len_i,
  input  logic [7:0]                    rd_data_i,
  input  logic                          short_hit_i,
  input  logic                          long_hit_i,
  output logic                          tmr_clr_o,
  output logic [$clog2(TX_DEPTH)-1:0]   rd_idx_o,
  output logic                          tx_clear_o,
  output logic                          tip_no,
  output logic                          ack_no,
  output logic                          sr_dir_o,
  output logic                          sr_load_o,
  output logic [7:0]                    sr_wdata_o,
  output logic                          rx_valid_o,
  output logic [7:0]                    rx_data_o,
  output logic                          rx_first_o,
  output logic                          rx_last_o,
  output logic [$clog2(RX_CAP+1)-1:0]   rx_len_o,
  output logic                          rx_ovf_o
);
  localparam int IW = $clog2(TX_DEPTH);
  localparam int LW = $clog2(TX_DEPTH + 1);
  localparam int RW = $clog2(RX_CAP + 1);

  lk_state_e state_q, state_d;
  logic          tip_q, tip_d, ack_q, ack_d, dir_q, dir_d;
  logic          load_q, load_d;
  logic [7:0]    wdata_q, wdata_d;
  logic [LW-1:0] scnt_q, scnt_d, scnt_n;
  logic [RW-1:0] rcnt_q, rcnt_d, rcnt_n;
  logic          rxv_q, rxv_d, rxf_q, rxf_d, rxl_q, rxl_d, ovf_q, ovf_d;
  logic [7:0]    rxd_q, rxd_d;
  logic [RW-1:0] rxlen_q, rxlen_d;
  logic          lat_q, lat_d;
  logic          req_on, evt, at_cap;

  assign req_on   = !req_ni;
  assign evt      = sr_done_i || lat_q;
  assign scnt_n   = scnt_q + LW'(1);
  assign rcnt_n   = rcnt_q + RW'(1);
  assign at_cap   = (rcnt_n == RW'(RX_CAP));
  assign rd_idx_o = (state_q == LK_SEND) ? scnt_q[IW-1:0] + IW'(1) : '0;

  always_comb begin
    state_d    = state_q;
    tip_d      = tip_q;
    ack_d      = ack_q;
    dir_d      = dir_q;
    load_d     = 1'b0;
    wdata_d    = wdata_q;
    scnt_d     = scnt_q;
    rcnt_d     = rcnt_q;
    rxv_d      = 1'b0;
    rxd_d      = rxd_q;
    rxf_d      = 1'b0;
    rxl_d      = 1'b0;
    rxlen_d    = rxlen_q;
    ovf_d      = 1'b0;
    lat_d      = lat_q || sr_done_i;
    tx_clear_o = 1'b0;
    unique case (state_q)
      LK_RST0: if (short_hit_i) begin state_d = LK_RST1; tip_d = 1'b0; end
      LK_RST1: if (short_hit_i) begin state_d = LK_RST2; ack_d = ~ack_q; end
      LK_RST2: if (short_hit_i) begin state_d = LK_RST3; tip_d = 1'b1; end
      LK_RST3: if (short_hit_i) begin state_d = LK_IDLE; tip_d = 1'b1; ack_d = 1'b1; end
      LK_IDLE: begin
        lat_d = 1'b0;
        if (evt && req_on) begin
          state_d = LK_RECV; rxv_d = 1'b1; rxf_d = 1'b1; rxd_d = sr_rdata_i;
          dir_d = 1'b0; tip_d = 1'b0; ack_d = 1'b1; rcnt_d = RW'(1);
        end else if (evt) begin
          if (pending_i) state_d = LK_GAP_SHORT;
        end else if (pending_i && !req_on) begin
          state_d = LK_SEND; dir_d = 1'b1; load_d = 1'b1; wdata_d = rd_data_i;
          ack_d = 1'b1; tip_d = 1'b0; scnt_d = '0;
        end
      end
      LK_SEND: begin
        lat_d = 1'b0;
        if (sr_done_i) begin
          if (req_on) begin
            // abort, same byte opens an incoming frame
            state_d = LK_RECV; rxv_d = 1'b1; rxf_d = 1'b1; rxd_d = sr_rdata_i;
            dir_d = 1'b0; tip_d = 1'b0; ack_d = 1'b1; rcnt_d = RW'(1); scnt_d = '0;
          end else if (scnt_n == len_i) begin
            state_d = LK_IDLE; tx_clear_o = 1'b1; dir_d = 1'b0;
            tip_d = 1'b1; ack_d = 1'b1; scnt_d = '0;
          end else begin
            load_d = 1'b1; wdata_d = rd_data_i; ack_d = ~ack_q; scnt_d = scnt_n;
          end
        end
      end
      LK_RECV: begin
        lat_d = 1'b0;
        if (sr_done_i) begin
          rxv_d = 1'b1; rxd_d = sr_rdata_i;
          if (!req_on || at_cap) begin
            rxl_d = 1'b1; rxlen_d = rcnt_n; ovf_d = req_on;
            tip_d = 1'b1; ack_d = 1'b1; rcnt_d = '0;
            state_d = pending_i ? LK_GAP_LONG : LK_IDLE;
          end else begin
            ack_d = ~ack_q; rcnt_d = rcnt_n;
          end
        end
      end
      LK_GAP_SHORT: if (short_hit_i) state_d = LK_IDLE;
      LK_GAP_LONG:  if (long_hit_i)  state_d = LK_IDLE;
      default: state_d = LK_IDLE;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_RST0;
      tip_q   <= 1'b1;
      ack_q   <= 1'b1;
      dir_q   <= 1'b0;
      load_q  <= 1'b0;
      wdata_q <= '0;
      scnt_q  <= '0;
      rcnt_q  <= '0;
      rxv_q   <= 1'b0;
      rxd_q   <= '0;
      rxf_q   <= 1'b0;
      rxl_q   <= 1'b0;
      rxlen_q <= '0;
      ovf_q   <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tip_q   <= tip_d;
      ack_q   <= ack_d;
      dir_q   <= dir_d;
      load_q  <= load_d;
      wdata_q <= wdata_d;
      scnt_q  <= scnt_d;
      rcnt_q  <= rcnt_d;
      rxv_q   <= rxv_d;
      rxd_q   <= rxd_d;
      rxf_q   <= rxf_d;
      rxl_q   <= rxl_d;
      rxlen_q <= rxlen_d;
      ovf_q   <= ovf_d;
      lat_q   <= lat_d;
    end
  end

  assign tip_no     = tip_q;
  assign ack_no     = ack_q;
  assign sr_dir_o   = dir_q;
  assign sr_load_o  = load_q;
  assign sr_wdata_o = wdata_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
  assign rx_first_o = rxf_q;
  assign rx_last_o  = rxl_q;
  assign rx_len_o   = rxlen_q;
  assign rx_ovf_o   = ovf_q;
endmodule

// File: rtl/link_host_ctrl.sv
module link_host_ctrl #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int TX_DEPTH = 16,
  parameter int RX_CAP   = 256
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tx_valid_i,
  input  logic [7:0]                  tx_data_i,
  input  logic                        tx_last_i,
  output logic                        tx_ready_o,
  output logic                        rx_valid_o,
  output logic [7:0]                  rx_data_o,
  output logic                        rx_first_o,
  output logic                        rx_last_o,
  output logic [$clog2(RX_CAP+1)-1:0] rx_len_o,
  output logic                        rx_ovf_o,
  input  logic                        sr_done_i,
  input  logic [7:0]                  sr_rdata_i,
  output logic                        sr_load_o,
  output logic [7:0]                  sr_wdata_o,
  output logic                        sr_dir_o,
  input  logic                        req_ni,
  output logic                        tip_no,
  output logic                        ack_no
);
  localparam int IW = $clog2(TX_DEPTH);
  localparam int LW = $clog2(TX_DEPTH + 1);

  logic          tmr_clr, short_hit, long_hit;
  logic          pending, tx_clear;
  logic [IW-1:0] rd_idx;
  logic [7:0]    rd_data;
  logic [LW-1:0] tx_len;

  lk_delay_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tmr_clr),
    .short_hit_o (short_hit),
    .long_hit_o  (long_hit)
  );

  lk_tx_store #(.DEPTH(TX_DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (tx_valid_i),
    .in_data_i  (tx_data_i),
    .in_last_i  (tx_last_i),
    .in_ready_o (tx_ready_o),
    .clear_i    (tx_clear),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .len_o      (tx_len),
    .pending_o  (pending)
  );

  lk_link_fsm #(.TX_DEPTH(TX_DEPTH), .RX_CAP(RX_CAP)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ni      (req_ni),
    .sr_done_i   (sr_done_i),
    .sr_rdata_i  (sr_rdata_i),
    .pending_i   (pending),
    .len_i       (tx_len),
    .rd_data_i   (rd_data),
    .short_hit_i (short_hit),
    .long_hit_i  (long_hit),
    .tmr_clr_o   (tmr_clr),
    .rd_idx_o    (rd_idx),
    .tx_clear_o  (tx_clear),
    .tip_no      (tip_no),
    .ack_no      (ack_no),
    .sr_dir_o    (sr_dir_o),
    .sr_load_o   (sr_load_o),
    .sr_wdata_o  (sr_wdata_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .rx_first_o  (rx_first_o),
    .rx_last_o   (rx_last_o),
    .rx_len_o    (rx_len_o),
    .rx_ovf_o    (rx_ovf_o)
  );
endmodule

// File: rtl/lk_link_chk.sv
module lk_link_chk #(
  parameter int RX_CAP = 256
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tx_valid_i,
  input logic                        tx_ready_o,
  input logic                        rx_valid_o,
  input logic                        rx_first_o,
  input logic                        rx_last_o,
  input logic [$clog2(RX_CAP+1)-1:0] rx_len_o,
  input logic                        rx_ovf_o,
  input logic                        sr_load_o,
  input logic                        sr_dir_o,
  input logic                        req_ni,
  input logic                        tip_no,
  input logic                        ack_no
);
  localparam int RW = $clog2(RX_CAP + 1);

  AST_LOAD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |-> (sr_dir_o && !tip_no)); // R3

  AST_SEND_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_dir_o) |-> $past(req_ni)); // R3

  AST_RX_START_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_first_o) |-> (!tip_no && !sr_dir_o && !rx_last_o)); // R6

  AST_RX_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_last_o) |-> (tip_no && ack_no)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> (rx_valid_o && rx_last_o && rx_len_o == RW'(RX_CAP))); // R8

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i)); // R12
endmodule

bind link_host_ctrl lk_link_chk #(.RX_CAP(RX_CAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_first_o (rx_first_o),
  .rx_last_o  (rx_last_o),
  .rx_len_o   (rx_len_o),
  .rx_ovf_o   (rx_ovf_o),
  .sr_load_o  (sr_load_o),
  .sr_dir_o   (sr_dir_o),
  .req_ni     (req_ni),
  .tip_no     (tip_no),
  .ack_no     (ack_no)
);

// File: tb/tb_link_host_ctrl.sv
module tb_link_host_ctrl;
  localparam int CLK_HZ = 1_000_000;
  localparam int SHORT  = 150;
  localparam int LONG   = 1500;

  typedef struct {
    logic [7:0] d;
    bit         f;
    bit         l;
    int         len;
    bit         o;
    string      tag;
  } rx_exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic       rx_valid, rx_first, rx_last, rx_ovf;
  logic [7:0] rx_data;
  logic [8:0] rx_len;
  logic       sr_done = 1'b0;
  logic [7:0] sr_rdata = '0;
  logic       sr_load, sr_dir;
  logic [7:0] sr_wdata;
  logic       req_n = 1'b1;
  logic       tip_n, ack_n;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_tx[$];
  rx_exp_t    exp_rx[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  link_host_ctrl #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_last_i(tx_last), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_first_o(rx_first), .rx_last_o(rx_last),
    .rx_len_o(rx_len), .rx_ovf_o(rx_ovf),
    .sr_done_i(sr_done), .sr_rdata_i(sr_rdata), .sr_load_o(sr_load), .sr_wdata_o(sr_wdata),
    .sr_dir_o(sr_dir), .req_ni(req_n), .tip_no(tip_n), .ack_no(ack_n)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic exp_rx_push(input logic [7:0] d, input bit f, input bit l,
                             input int len, input bit o, input string tag);
    rx_exp_t e;
    e.d = d; e.f = f; e.l = l; e.len = len; e.o = o; e.tag = tag;
    exp_rx.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sr_load) begin
      if (exp_tx.size() == 0) chk(1'b0, "R4 unexpected load", sr_wdata, -1);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        chk(sr_wdata == e, "R4 loaded byte", sr_wdata, e);
      end
    end
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, "R9 unexpected rx byte", rx_data, -1);
      else begin
        rx_exp_t e;
        e = exp_rx.pop_front();
        chk(rx_data == e.d, {e.tag, " rx data"}, rx_data, e.d);
        chk(rx_first == e.f && rx_last == e.l && rx_ovf == e.o, {e.tag, " rx marks"},
            {rx_first, rx_last, rx_ovf}, {e.f, e.l, e.o});
        if (e.l) chk(int'(rx_len) == e.len, {e.tag, " rx length"}, rx_len, e.len);
      end
    end
  end

  task automatic push_tx(input logic [7:0] b[]);
    foreach (b[i]) begin
      tx_valid = 1'b1; tx_data = b[i]; tx_last = (i == b.size() - 1);
      exp_tx.push_back(b[i]);
      @(negedge clk);
    end
    tx_valid = 1'b0; tx_last = 1'b0;
  endtask

  task automatic wait_load(output int waited);
    waited = 0;
    while (!sr_load && waited < 4000) begin @(negedge clk); waited++; end
  endtask

  task automatic pulse_done();
    sr_done = 1'b1; @(negedge clk); sr_done = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input bit keep);
    sr_rdata = d; req_n = keep ? 1'b0 : 1'b1;
    pulse_done();
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, w, a0;
    idle_cycles(3);
    chk(tip_n && ack_n && !sr_dir, "R2 reset state lines", {tip_n, ack_n, sr_dir}, 3'b110);
    rst_n = 1'b1;
    // R1 handshake order and spacing
    n = 0; while (tip_n && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SHORT - 1 && n <= SHORT + 1 && ack_n, "R1 tip assert step", n, SHORT);
    n = 0; while (ack_n && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SHORT - 1 && n <= SHORT + 1 && !tip_n, "R1 ack toggle step", n, SHORT);
    n = 0; while (!tip_n && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SHORT - 1 && n <= SHORT + 1 && !ack_n, "R1 tip release step", n, SHORT);
    n = 0; while (!ack_n && n < 1000) begin @(negedge clk); n++; end
    chk(n >= SHORT - 1 && n <= SHORT + 1, "R1 ack release step", n, SHORT);
    idle_cycles(3);
    chk(tip_n && ack_n && !sr_dir && tx_ready, "R2 idle after handshake",
        {tip_n, ack_n, sr_dir, tx_ready}, 4'b1101);

    // plain send
    push_tx('{8'h11, 8'h22, 8'h33});
    wait_load(w);
    chk(sr_dir && !tip_n && ack_n, "R3 send start lines", {sr_dir, tip_n, ack_n}, 3'b101);
    chk(!tx_ready, "R12 ready low while pending", tx_ready, 0);
    a0 = ack_n;
    pulse_done();
    chk(ack_n != a0 && sr_load, "R4 ack toggles with next load", ack_n, !a0);
    pulse_done();
    pulse_done();
    idle_cycles(2);
    chk(tip_n && ack_n && !sr_dir && tx_ready, "R4 send complete idle",
        {tip_n, ack_n, sr_dir, tx_ready}, 4'b1101);

    // plain receive
    req_n = 1'b0; idle_cycles(2);
    exp_rx_push(8'hA0, 1, 0, 0, 0, "R6");
    rx_byte(8'hA0, 1);
    chk(!tip_n && !sr_dir, "R6 receive opens frame", {tip_n, sr_dir}, 0);
    a0 = ack_n;
    exp_rx_push(8'h01, 0, 0, 0, 0, "R7");
    rx_byte(8'h01, 1);
    chk(ack_n != a0, "R7 ack toggles for more", ack_n, !a0);
    exp_rx_push(8'h02, 0, 0, 0, 0, "R7");
    rx_byte(8'h02, 1);
    exp_rx_push(8'h03, 0, 1, 4, 0, "R7");
    rx_byte(8'h03, 0);
    chk(tip_n && ack_n, "R7 frame end releases lines", {tip_n, ack_n}, 3);

    // false start, nothing pending: ignored
    idle_cycles(3);
    rx_byte(8'h55, 0);
    idle_cycles(3);
    chk(tip_n && ack_n && !sr_dir, "R9 false start ignored", {tip_n, ack_n, sr_dir}, 6);

    // false start coinciding with fresh pending packet
    exp_tx.push_back(8'h40); exp_tx.push_back(8'h41);
    tx_valid = 1'b1; tx_data = 8'h40; tx_last = 1'b0; @(negedge clk);
    tx_data = 8'h41; tx_last = 1'b1; @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0; sr_rdata = 8'h5A; req_n = 1'b1;
    pulse_done();
    wait_load(w);
    chk(w >= SHORT - 1 && w <= SHORT + 6, "R9 send deferred by false start", w, SHORT);
    pulse_done();
    pulse_done();
    idle_cycles(2);
    chk(tx_ready, "R12 ready after completion", tx_ready, 1);

    // collision abort, latched pulse during long guard, resend
    push_tx('{8'h60, 8'h61, 8'h62});
    exp_tx.push_front(8'h60);
    wait_load(w);
    exp_rx_push(8'hC1, 1, 0, 0, 0, "R5");
    rx_byte(8'hC1, 1);
    chk(!tip_n && !sr_dir && ack_n, "R5 abort opens receive", {tip_n, sr_dir, ack_n}, 1);
    exp_rx_push(8'hC2, 0, 1, 2, 0, "R5");
    rx_byte(8'hC2, 0);
    idle_cycles(200);
    chk(tip_n && !sr_dir, "R10 no send during long guard", {tip_n, sr_dir}, 2);
    exp_rx_push(8'hD1, 1, 0, 0, 0, "R11");
    rx_byte(8'hD1, 1);
    idle_cycles(10);
    chk(tip_n, "R11 pulse held during guard", tip_n, 1);
    idle_cycles(LONG - 200);
    chk(!tip_n && !sr_dir, "R11 held pulse starts receive", {tip_n, sr_dir}, 0);
    exp_rx_push(8'hD2, 0, 1, 2, 0, "R10");
    rx_byte(8'hD2, 0);
    wait_load(w);
    chk(w >= LONG - 1 && w <= LONG + 6, "R10 resend after long guard", w, LONG);
    chk(sr_wdata == 8'h60, "R5 resend from byte 0", sr_wdata, 8'h60);
    pulse_done();
    pulse_done();
    pulse_done();
    idle_cycles(2);
    chk(tip_n && tx_ready, "R4 resend complete", {tip_n, tx_ready}, 3);

    // overflow
    req_n = 1'b0; idle_cycles(2);
    exp_rx_push(8'hE0, 1, 0, 0, 0, "R8");
    rx_byte(8'hE0, 1);
    for (int i = 1; i < 256; i++) begin
      exp_rx_push(8'(i), 0, (i == 255), 256, (i == 255), "R8");
      rx_byte(8'(i), 1);
    end
    chk(tip_n && ack_n, "R8 cap ends frame", {tip_n, ack_n}, 3);
    req_n = 1'b1;
    idle_cycles(5);

    chk(exp_tx.size() == 0, "R4 all loads seen", exp_tx.size(), 0);
    chk(exp_rx.size() == 0, "R7 all rx bytes seen", exp_rx.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule